// File: doc/BRIEF.md
# GPIO Port Register Bank with Masked-Write Aliases

This block holds the control and status registers for one bank of general-purpose pins. The bank has four ports of eight pins each and is reached through a simple memory-mapped read/write bus with one-cycle read latency. For each port it keeps these registers:

- mode-enable
- output-enable
- output value
- input sample
- interrupt status
- interrupt enable
- interrupt type
- interrupt clear

It drives the pad output and pad drive-enable signals and brings the pad levels in through a two-flop synchroniser.

Every writable register can also be reached through a masked alias window. A write there changes only the pins whose mask bit is set, so software can update one pin without reading the register first. Edge and level detection sit in a separate block. That block raises bits through a set input and reads enables and types from outputs of this block.

The bank's plain window starts at `BANK_INDEX * BANK_STRIDE`. The alias window starts `ALIAS_OFFSET` above it. A pin with index n is in port n[4:3] at bit n[2:0].

Top module: `pinbank_regs`

## Requirements
- R1: After reset every register reads zero, `pad_oe`, `pad_out`, `irq_en`, `irq_type` and `irq_status` are zero, and `bus_rdata` is zero.
- R2: A plain write at window offset group*0x10 + port*4 stores `bus_wdata[7:0]` into that port's register. The groups are 0 mode-enable, 1 output-enable, 2 output, 3 input, 4 status, 5 interrupt enable, 6 interrupt type and 7 clear. A read asserted at one edge presents the register in `bus_rdata[7:0]` after that edge, with bits [31:8] zero. In a cycle after an edge with no read, `bus_rdata` is zero.
- R3: A write in the alias window updates only the pins whose bit in `bus_wdata[15:8]` is 1, each taking its value from `bus_wdata[7:0]`. Pins with a 0 mask bit keep their value.
- R4: Aliases exist for groups 0, 1, 2, 4, 5 and 6. Alias writes at the group 3 and group 7 offsets change nothing, and every read in the alias window returns zero.
- R5: `pad_oe[i]` is 1 exactly when both mode-enable and output-enable are 1 for pin i. `pad_out` equals the output register.
- R6: Reading group 3 returns `pad_in` for that port. A level applied before edge k is returned by a read sampled at edge k+2, and reads sampled at edges k and k+1 still return the older level.
- R7: An `irq_set` bit sets its status bit at the next edge. A plain write to group 7 clears the status bits written as 1. When a set and a clear hit the same bit in the same cycle, the set wins. Group 7 reads zero.
- R8: Reads of unmapped or misaligned addresses return zero, and writes there change nothing.
- R9: `irq_en`, `irq_type` and `irq_status` mirror the interrupt enable, interrupt type and status registers, with bit port*8+b belonging to pin b of that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data; [15:8] mask and [7:0] value in the alias window |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| pad_in | input | NUM_PORTS*8 | Asynchronous pad levels |
| pad_out | output | NUM_PORTS*8 | Pad output values |
| pad_oe | output | NUM_PORTS*8 | Pad drive enables |
| irq_set | input | NUM_PORTS*8 | Status set pulses from the detection block |
| irq_status | output | NUM_PORTS*8 | Interrupt status |
| irq_en | output | NUM_PORTS*8 | Interrupt enables |
| irq_type | output | NUM_PORTS*8 | Interrupt type bits |

## Verification
Register writes take effect at the write edge, so a read strobed in the next cycle sees them. Read data is sampled at the falling edge after the read edge. Pad outputs, enables and status are sampled at the falling edge after the edge that loaded them. Pad-input reads are checked at the exact edges around the two-stage synchroniser: two stale values, then the new one. Settle-only checks wait three edges after a pad change.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    localparam int PORT_PINS = 8;
    localparam int GROUPS    = 8;
    localparam int GROUP_SPAN = 16;

    typedef enum logic [2:0] {
        G_MODE = 3'd0,
        G_DIR  = 3'd1,
        G_OUTV = 3'd2,
        G_INP  = 3'd3,
        G_STAT = 3'd4,
        G_IEN  = 3'd5,
        G_ITYP = 3'd6,
        G_ICLR = 3'd7
    } grp_e;

    typedef struct packed {
        logic [PORT_PINS-1:0] mode;
        logic [PORT_PINS-1:0] dir;
        logic [PORT_PINS-1:0] outv;
        logic [PORT_PINS-1:0] stat;
        logic [PORT_PINS-1:0] ien;
        logic [PORT_PINS-1:0] ityp;
    } port_regs_t;

    function automatic logic [PORT_PINS-1:0] merge_bits(
        input logic [PORT_PINS-1:0] old_v,
        input logic [PORT_PINS-1:0] new_v,
        input logic [PORT_PINS-1:0] sel);
        return (old_v & ~sel) | (new_v & sel);
    endfunction
endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
    import pinbank_pkg::*;
#(
    parameter int NUM_PORTS    = 4,
    parameter int ADDR_W       = 12,
    parameter int BANK_STRIDE  = 128,
    parameter int ALIAS_OFFSET = 2048,
    parameter int BANK_INDEX   = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              plain_hit,
    output logic              alias_hit,
    output grp_e              grp,
    output logic [1:0]        port
);
    localparam int BASE  = BANK_INDEX * BANK_STRIDE;
    localparam int ABASE = BASE + ALIAS_OFFSET;
    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] ABASE_A = ADDR_W'(ABASE);
    localparam logic [ADDR_W-1:0] SPAN_A  = ADDR_W'(GROUPS * GROUP_SPAN);

    logic [ADDR_W-1:0] off_p;
    logic [ADDR_W-1:0] off_a;
    logic              in_p;
    logic              in_a;
    logic [ADDR_W-1:0] off_sel;
    logic              fmt_ok;

    always_comb begin
        off_p   = addr - BASE_A;
        off_a   = addr - ABASE_A;
        in_p    = (addr >= BASE_A) && (off_p < SPAN_A);
        in_a    = (addr >= ABASE_A) && (off_a < SPAN_A);
        off_sel = in_a ? off_a : off_p;
        grp     = grp_e'(off_sel[6:4]);
        port    = off_sel[3:2];
        fmt_ok  = (off_sel[1:0] == 2'b00) && (int'(off_sel[3:2]) < NUM_PORTS);
        plain_hit = in_p && fmt_ok;
        alias_hit = in_a && !in_p && fmt_ok && (grp != G_INP) && (grp != G_ICLR);
    end
endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
    import pinbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_plain,
    input  logic                 wr_alias,
    input  grp_e                 grp,
    input  logic [15:0]          wdata,
    input  logic [PORT_PINS-1:0] set_bits,
    output port_regs_t           regs
);
    port_regs_t regs_d;
    port_regs_t regs_q;
    logic [PORT_PINS-1:0] sel;
    logic [PORT_PINS-1:0] val;

    always_comb begin
        regs_d = regs_q;
        sel    = wr_alias ? wdata[15:8] : {PORT_PINS{1'b1}};
        val    = wdata[7:0];
        if (wr_plain || wr_alias) begin
            case (grp)
                G_MODE: regs_d.mode = merge_bits(regs_q.mode, val, sel);
                G_DIR:  regs_d.dir  = merge_bits(regs_q.dir,  val, sel);
                G_OUTV: regs_d.outv = merge_bits(regs_q.outv, val, sel);
                G_STAT: regs_d.stat = merge_bits(regs_q.stat, val, sel);
                G_IEN:  regs_d.ien  = merge_bits(regs_q.ien,  val, sel);
                G_ITYP: regs_d.ityp = merge_bits(regs_q.ityp, val, sel);
                G_ICLR: if (wr_plain) regs_d.stat = regs_q.stat & ~val;
                default: ;
            endcase
        end
        regs_d.stat = regs_d.stat | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d;
    sync_t st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int NUM_PORTS    = 4,
    parameter int ADDR_W       = 12,
    parameter int BANK_STRIDE  = 128,
    parameter int ALIAS_OFFSET = 2048,
    parameter int BANK_INDEX   = 0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr_en,
    input  logic                           bus_rd_en,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    input  logic [NUM_PORTS*PORT_PINS-1:0] pad_in,
    output logic [NUM_PORTS*PORT_PINS-1:0] pad_out,
    output logic [NUM_PORTS*PORT_PINS-1:0] pad_oe,
    input  logic [NUM_PORTS*PORT_PINS-1:0] irq_set,
    output logic [NUM_PORTS*PORT_PINS-1:0] irq_status,
    output logic [NUM_PORTS*PORT_PINS-1:0] irq_en,
    output logic [NUM_PORTS*PORT_PINS-1:0] irq_type
);
    localparam int NPINS = NUM_PORTS * PORT_PINS;

    logic       plain_hit;
    logic       alias_hit;
    grp_e       grp;
    logic [1:0] port;

    port_regs_t             regs_q [NUM_PORTS];
    logic [NPINS-1:0]       in_sync;
    logic [NPINS-1:0]       mode_vec;
    logic [31:0]            rdata_d;
    logic [31:0]            rdata_q;
    logic [PORT_PINS-1:0]   rd_byte;

    pinbank_decode #(
        .NUM_PORTS   (NUM_PORTS),
        .ADDR_W      (ADDR_W),
        .BANK_STRIDE (BANK_STRIDE),
        .ALIAS_OFFSET(ALIAS_OFFSET),
        .BANK_INDEX  (BANK_INDEX)
    ) u_dec (
        .addr     (bus_addr),
        .plain_hit(plain_hit),
        .alias_hit(alias_hit),
        .grp      (grp),
        .port     (port)
    );

    pinbank_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (in_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic sel_p;
        assign sel_p = (int'(port) == p);

        pinbank_port u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_plain(bus_wr_en && plain_hit && sel_p),
            .wr_alias(bus_wr_en && alias_hit && sel_p),
            .grp     (grp),
            .wdata   (bus_wdata[15:0]),
            .set_bits(irq_set[p*PORT_PINS +: PORT_PINS]),
            .regs    (regs_q[p])
        );

        assign mode_vec  [p*PORT_PINS +: PORT_PINS] = regs_q[p].mode;
        assign pad_out   [p*PORT_PINS +: PORT_PINS] = regs_q[p].outv;
        assign pad_oe    [p*PORT_PINS +: PORT_PINS] = regs_q[p].mode & regs_q[p].dir;
        assign irq_status[p*PORT_PINS +: PORT_PINS] = regs_q[p].stat;
        assign irq_en    [p*PORT_PINS +: PORT_PINS] = regs_q[p].ien;
        assign irq_type  [p*PORT_PINS +: PORT_PINS] = regs_q[p].ityp;
    end

    always_comb begin
        rd_byte = '0;
        case (grp)
            G_MODE: rd_byte = regs_q[port].mode;
            G_DIR:  rd_byte = regs_q[port].dir;
            G_OUTV: rd_byte = regs_q[port].outv;
            G_INP:  rd_byte = in_sync[int'(port)*PORT_PINS +: PORT_PINS];
            G_STAT: rd_byte = regs_q[port].stat;
            G_IEN:  rd_byte = regs_q[port].ien;
            G_ITYP: rd_byte = regs_q[port].ityp;
            default: rd_byte = '0;
        endcase
        rdata_d = '0;
        if (bus_rd_en && plain_hit) rdata_d = {24'd0, rd_byte};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/pinbank_checker.sv
module pinbank_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr_en,
    input logic         bus_rd_en,
    input logic [31:0]  bus_rdata,
    input logic [W-1:0] irq_set,
    input logic [W-1:0] irq_status,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] mode_vec
);
    p_oe_needs_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~mode_vec) == '0);

    p_set_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_set) |=> ((irq_status & $past(irq_set)) == $past(irq_set)));

    p_status_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_en && irq_set == '0) |=> (irq_status == $past(irq_status)));

    p_rise_needs_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_en |=> ((irq_status & ~$past(irq_status) & ~$past(irq_set)) == '0));

    p_idle_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> (bus_rdata == '0));
endmodule

bind pinbank_regs pinbank_checker #(.W($bits(pad_oe))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_rdata (bus_rdata),
    .irq_set   (irq_set),
    .irq_status(irq_status),
    .pad_oe    (pad_oe),
    .mode_vec  (mode_vec)
);

// File: tb/pinbank_regs_test.sv
module pinbank_regs_test;
    localparam int AW    = 12;
    localparam int BASE  = 32'h100;
    localparam int ABASE = 32'h180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, irq_status, irq_en, irq_type;
    logic [31:0] irq_set = '0;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [8][4];

    always #2 clk = ~clk;

    pinbank_regs #(
        .NUM_PORTS(4), .ADDR_W(AW), .BANK_STRIDE(256),
        .ALIAS_OFFSET(128), .BANK_INDEX(1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_set(irq_set),
        .irq_status(irq_status), .irq_en(irq_en), .irq_type(irq_type)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] pa(input int g, input int p);
        return AW'(BASE + g*16 + p*4);
    endfunction

    function automatic logic [AW-1:0] aa(input int g, input int p);
        return AW'(ABASE + g*16 + p*4);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] vec(input int g);
        return {mdl[g][3], mdl[g][2], mdl[g][1], mdl[g][0]};
    endfunction

    task automatic check_all(input string req);
        logic [31:0] d;
        for (int g = 0; g < 7; g++) begin
            if (g == 3) continue;
            for (int p = 0; p < 4; p++) begin
                rd(pa(g, p), d);
                check(req, d, {24'd0, mdl[g][p]});
            end
        end
    endtask

    task automatic check_outs(input string req);
        check(req, pad_out, vec(2));
        check(req, pad_oe, vec(0) & vec(1));
        check(req, irq_status, vec(4));
        check(req, irq_en, vec(5));
        check(req, irq_type, vec(6));
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0] masks [4];
        masks[0] = 8'h00; masks[1] = 8'hFF; masks[2] = 8'h5A; masks[3] = 8'h81;
        for (int g = 0; g < 8; g++) for (int p = 0; p < 4; p++) mdl[g][p] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 outputs", pad_oe | pad_out | irq_status | irq_en | irq_type, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        for (int g = 0; g < 8; g++)
            for (int p = 0; p < 4; p++) begin
                rd(pa(g, p), d);
                check("R1 reg", d, 32'd0);
            end

        // R2: plain write sweep, junk in upper bits
        for (int g = 0; g < 7; g++) begin
            if (g == 3) continue;
            for (int p = 0; p < 4; p++) begin
                mdl[g][p] = 8'((g*37 + p*11 + 5) & 255);
                wr(pa(g, p), {24'hA5C3E7, mdl[g][p]});
            end
        end
        check_all("R2 plain readback");
        check_outs("R5 R9 outputs after plain");

        // R3: masked alias sweep
        for (int g = 0; g < 7; g++) begin
            if (g == 3) continue;
            for (int p = 0; p < 4; p++)
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] v;
                    v = ~mdl[g][p] ^ 8'(k);
                    wr(aa(g, p), {16'hBEEF, masks[k], v});
                    mdl[g][p] = (mdl[g][p] & ~masks[k]) | (v & masks[k]);
                end
        end
        check_all("R3 masked readback");
        check_outs("R5 R9 outputs after masked");

        // R4: alias at input/clear offsets ignored, alias reads zero
        for (int p = 0; p < 4; p++) begin
            wr(aa(3, p), 32'h0000FFFF);
            wr(aa(7, p), 32'h0000FFFF);
        end
        check_all("R4 no alias for input/clear");
        rd(aa(0, 1), d);
        check("R4 alias read zero", d, 32'd0);
        rd(aa(5, 2), d);
        check("R4 alias read zero", d, 32'd0);

        // R8: unmapped and misaligned
        wr(AW'(BASE - 4), 32'hFF);
        wr(AW'(BASE + 2), 32'hFF);
        wr(AW'(BASE + 32'h21), 32'hFF);
        wr(AW'(0), 32'hFF);
        wr(AW'(ABASE + 32'h80), 32'hFFFF);
        wr(AW'(ABASE + 32'h52), 32'hFFFF);
        check_all("R8 unmapped writes ignored");
        rd(AW'(BASE + 2), d);
        check("R8 misaligned read", d, 32'd0);
        rd(AW'(BASE - 4), d);
        check("R8 unmapped read", d, 32'd0);
        rd(AW'(32'h400), d);
        check("R8 unmapped read", d, 32'd0);

        // R6: synchroniser timing, port 2
        pad_in = 32'h00_00_00_00;
        repeat (3) @(negedge clk);
        pad_in = 32'h00_3C_00_00;
        rd(pa(3, 2), d);
        check("R6 edge k old", d, 32'h00);
        rd(pa(3, 2), d);
        check("R6 edge k+1 old", d, 32'h00);
        rd(pa(3, 2), d);
        check("R6 edge k+2 new", d, 32'h3C);
        // R6: settled sweep across ports
        for (int t = 0; t < 6; t++) begin
            pad_in = 32'h1357_9BDF * (t + 1) ^ (32'hFF << (t * 4));
            repeat (3) @(negedge clk);
            for (int p = 0; p < 4; p++) begin
                rd(pa(3, p), d);
                check("R6 input", d, {24'd0, pad_in[p*8 +: 8]});
            end
        end

        // R7: status set, clear, set-wins
        for (int p = 0; p < 4; p++) begin
            wr(pa(4, p), 32'h0);
            mdl[4][p] = 8'h00;
        end
        irq_set = 32'h0180_2001;
        @(negedge clk);
        irq_set = 32'h0;
        check("R7 set", irq_status, 32'h0180_2001);
        rd(pa(4, 0), d);
        check("R7 status read", d, 32'h01);
        wr(pa(7, 0), 32'h01);
        check("R7 w1c", irq_status, 32'h0180_2000);
        bus_wr_en = 1'b1; bus_addr = pa(7, 3); bus_wdata = 32'h81;
        irq_set = 32'h8000_0000;
        @(negedge clk);
        bus_wr_en = 1'b0; irq_set = 32'h0;
        check("R7 set wins", irq_status, 32'h8080_2000);
        rd(pa(7, 3), d);
        check("R7 clear reads zero", d, 32'd0);
        mdl[4][0] = 8'h00; mdl[4][1] = 8'h20; mdl[4][2] = 8'h80; mdl[4][3] = 8'h80;
        check_outs("R9 final outputs");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule